// File: doc/BRIEF.md
# SPI Register-Access Slave Front End

This block lets an external SPI host read and write a bank of 8-bit configuration and status registers. The host frames each transaction with an active-low chip select. Inside one frame it sends a command byte, then a two-byte register address with the low byte first. For a write, the data bytes follow at once. For a read, the slave shifts the requested bytes back out. The block turns each frame into single-cycle strobes on a plain parallel register port. The register file and the interrupt logic outside the block own the register contents.

All SPI pins are oversampled by the system clock through synchronizers, so the register port sits entirely in the system clock domain. The SPI clock half period must be at least 8 system clock cycles with the default of two synchronizer stages. The register file must return read data on `reg_rdata` in the cycle after `reg_rd` is high. MISO comes out as a data bit plus an enable, and the pad tristate is built from the two.

Top module: `spi_regbus_slave`

## Requirements
- R1: After reset, `reg_wr`, `reg_rd`, `crc_err` and `spi_miso_oe` are all low.
- R2: Command byte bit 7 chooses the direction (1 = write, 0 = read), and bits 3:0 give the byte count minus one (1 to 16 bytes). Bits 5:4 have no effect.
- R3: The two bytes after the command form the start address, low byte first, then high byte.
- R4: In a write frame, each data byte produces one single-cycle `reg_wr` pulse with that byte on `reg_wdata`. The first byte goes to the start address, and each later byte goes to the previous address plus one.
- R5: In a read frame, `reg_rd` pulses once per requested byte at the start address, then at each later address plus one. Each returned byte appears on `spi_miso` MSB first in SPI mode 0, valid before the first rising SCLK edge of its byte slot.
- R6: If command bit 6 is set, the frame performs no register access, and `crc_err` pulses high for exactly one cycle.
- R7: Write-frame bytes beyond the declared count cause no `reg_wr`.
- R8: Raising `spi_cs_n` at any point ends the frame. A partly received byte is dropped, and the next frame is decoded from its command byte.
- R9: `spi_miso_oe` is high exactly while `spi_cs_n` is low.
- R10: In a read frame, SCLK bytes beyond the declared count shift out zeros and cause no `reg_rd`.
- R11: `reg_wr` and `reg_rd` are never high together, and neither stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Host-to-slave serial data |
| spi_miso | output | 1 | Slave-to-host serial data bit |
| spi_miso_oe | output | 1 | Drive enable for the MISO pad |
| reg_addr | output | ADDR_W | Register address for the current strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | Single-cycle register write strobe |
| reg_rd | output | 1 | Single-cycle register read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd` |
| crc_err | output | 1 | Single-cycle pulse when a frame requests CRC |

## Verification
The bench targets the byte boundaries where the design is easiest to get wrong. A full 16-byte burst whose addresses cross 0x100 catches a bad count field or an 8-bit address wrap. Extra bytes after the count catch a design that keeps writing or reads past the end and repeats stale MISO bits. Chip select is pulled mid-byte and mid-command. A design that commits the partial byte, or that resumes decoding with a stale state, shows up there as a wrong write or a misread next frame. A frame with the CRC flag set must produce one pulse and no access. Read data is checked bit by bit at the host's sampling edge, which exposes a byte loaded too late or shifted once too often.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
   localparam int BYTE_W   = 8;
   localparam int CNT_W    = 4;
   localparam int DIR_BIT  = 7;
   localparam int CRC_BIT  = 6;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_ALO,
      ST_AHI,
      ST_WR,
      ST_RD,
      ST_DROP
   } frame_st_e;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
   parameter int             WIDTH   = 1,
   parameter int             STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_slv_shifter.sv
module spi_slv_shifter
   import spi_slv_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              mosi_s,
   input  logic              tx_load,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              rx_valid,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              miso_bit
);
   localparam int BIT_W = $clog2(BYTE_W);

   logic              sclk_q;
   logic              rise, fall;
   logic [BIT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] rx_sr;
   logic [BYTE_W-1:0] tx_sr;
   logic              last_bit;

   assign rise     = sclk_s & ~sclk_q;
   assign fall     = ~sclk_s & sclk_q;
   assign last_bit = (bit_cnt == BIT_W'(BYTE_W - 1));
   assign miso_bit = tx_sr[BYTE_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         bit_cnt  <= '0;
         rx_sr    <= '0;
         rx_byte  <= '0;
         rx_valid <= 1'b0;
         tx_sr    <= '0;
      end else begin
         sclk_q   <= sclk_s;
         rx_valid <= 1'b0;
         if (cs_n_s) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
         end else begin
            if (rise) begin
               rx_sr   <= {rx_sr[BYTE_W-3:0], mosi_s};
               bit_cnt <= bit_cnt + 1'b1;
               if (last_bit) begin
                  rx_valid <= 1'b1;
                  rx_byte  <= {rx_sr, mosi_s};
               end
            end
            if (tx_load)
               tx_sr <= tx_byte;
            else if (rise && last_bit)
               tx_sr <= '0;
            else if (fall && bit_cnt != '0)
               tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
         end
      end
   end
endmodule

// File: rtl/spi_slv_frame.sv
module spi_slv_frame
   import spi_slv_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_s,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic [BYTE_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   output logic              crc_err,
   output logic              tx_load,
   output logic [BYTE_W-1:0] tx_byte
);
   frame_st_e         st;
   logic [CNT_W-1:0]  remain;
   logic [ADDR_W-1:0] addr;
   logic              is_wr;
   logic              load_q;

   assign reg_addr = addr;
   assign tx_load  = load_q;
   assign tx_byte  = reg_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_CMD;
         remain    <= '0;
         addr      <= '0;
         is_wr     <= 1'b0;
         load_q    <= 1'b0;
         reg_wdata <= '0;
         reg_wr    <= 1'b0;
         reg_rd    <= 1'b0;
         crc_err   <= 1'b0;
      end else begin
         reg_wr  <= 1'b0;
         reg_rd  <= 1'b0;
         crc_err <= 1'b0;
         load_q  <= reg_rd & ~cs_n_s;
         if (reg_wr) addr <= addr + 1'b1;
         if (cs_n_s) begin
            st <= ST_CMD;
         end else if (rx_valid) begin
            unique case (st)
               ST_CMD: begin
                  if (rx_byte[CRC_BIT]) begin
                     crc_err <= 1'b1;
                     st      <= ST_DROP;
                  end else begin
                     is_wr  <= rx_byte[DIR_BIT];
                     remain <= rx_byte[CNT_W-1:0];
                     st     <= ST_ALO;
                  end
               end
               ST_ALO: begin
                  addr[BYTE_W-1:0] <= rx_byte;
                  st               <= ST_AHI;
               end
               ST_AHI: begin
                  addr <= ADDR_W'({rx_byte, addr[BYTE_W-1:0]});
                  if (is_wr) begin
                     st <= ST_WR;
                  end else begin
                     reg_rd <= 1'b1;
                     st     <= ST_RD;
                  end
               end
               ST_WR: begin
                  reg_wr    <= 1'b1;
                  reg_wdata <= rx_byte;
                  if (remain == '0) st <= ST_DROP;
                  else              remain <= remain - 1'b1;
               end
               ST_RD: begin
                  if (remain == '0) begin
                     st <= ST_DROP;
                  end else begin
                     remain <= remain - 1'b1;
                     addr   <= addr + 1'b1;
                     reg_rd <= 1'b1;
                  end
               end
               default: st <= ST_DROP;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_regbus_slave.sv
module spi_regbus_slave
   import spi_slv_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [7:0]        reg_wdata,
   output logic              reg_wr,
   output logic              reg_rd,
   input  logic [7:0]        reg_rdata,
   output logic              crc_err
);
   generate
      if (ADDR_W < BYTE_W || ADDR_W > 2 * BYTE_W) begin : g_bad_addr
         $error("ADDR_W must lie between 8 and 16");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 8) begin : g_bad_sync
         $error("SYNC_STAGES must lie between 2 and 8");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              sclk_s, cs_n_s, mosi_s;
   logic              rx_valid;
   logic [BYTE_W-1:0] rx_byte;
   logic              tx_load;
   logic [BYTE_W-1:0] tx_byte;

   spi_slv_sync #(
      .WIDTH  (3),
      .STAGES (SYNC_STAGES),
      .RST_VAL(3'b010)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({spi_mosi, spi_cs_n, spi_sclk}),
      .q    (pins_s)
   );

   assign sclk_s = pins_s[0];
   assign cs_n_s = pins_s[1];
   assign mosi_s = pins_s[2];

   spi_slv_shifter u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (sclk_s),
      .cs_n_s  (cs_n_s),
      .mosi_s  (mosi_s),
      .tx_load (tx_load),
      .tx_byte (tx_byte),
      .rx_valid(rx_valid),
      .rx_byte (rx_byte),
      .miso_bit(spi_miso)
   );

   spi_slv_frame #(.ADDR_W(ADDR_W)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_n_s   (cs_n_s),
      .rx_valid (rx_valid),
      .rx_byte  (rx_byte),
      .reg_rdata(reg_rdata),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .crc_err  (crc_err),
      .tx_load  (tx_load),
      .tx_byte  (tx_byte)
   );

   assign spi_miso_oe = ~spi_cs_n & rst_n;
endmodule

// File: rtl/spi_regbus_slave_chk.sv
module spi_regbus_slave_chk #(
   parameter int ADDR_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_sclk,
   input logic              spi_cs_n,
   input logic              spi_mosi,
   input logic              spi_miso,
   input logic              spi_miso_oe,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [7:0]        reg_rdata,
   input logic              crc_err
);
   logic [7:0]        idle_cnt;
   logic [5:0]        wr_cnt;
   logic              seen_wr, seen_rd, crc_seen;
   logic [ADDR_W-1:0] last_wr, last_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_cnt <= '0;
         wr_cnt   <= '0;
         seen_wr  <= 1'b0;
         seen_rd  <= 1'b0;
         crc_seen <= 1'b0;
         last_wr  <= '0;
         last_rd  <= '0;
      end else if (spi_cs_n) begin
         if (idle_cnt != 8'hFF) idle_cnt <= idle_cnt + 1'b1;
         wr_cnt   <= '0;
         seen_wr  <= 1'b0;
         seen_rd  <= 1'b0;
         crc_seen <= 1'b0;
      end else begin
         idle_cnt <= '0;
         if (reg_wr) begin
            wr_cnt  <= wr_cnt + 1'b1;
            seen_wr <= 1'b1;
            last_wr <= reg_addr;
         end
         if (reg_rd) begin
            seen_rd <= 1'b1;
            last_rd <= reg_addr;
         end
         if (crc_err) crc_seen <= 1'b1;
      end
   end

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));
   p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);
   p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> !reg_rd);
   p_crc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      crc_err |=> !crc_err);
   p_crc_no_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
      crc_seen |-> !reg_wr && !reg_rd);
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_cnt > 8'(SYNC_STAGES + 4)) |-> !reg_wr && !reg_rd && !crc_err);
   p_wr_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && seen_wr && !spi_cs_n) |-> reg_addr == ADDR_W'(last_wr + 1'b1));
   p_rd_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && seen_rd && !spi_cs_n) |-> reg_addr == ADDR_W'(last_rd + 1'b1));
   p_wr_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt <= 6'd16);
endmodule

bind spi_regbus_slave spi_regbus_slave_chk #(
   .ADDR_W     (ADDR_W),
   .SYNC_STAGES(SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_spi_regbus_slave.sv
module sim_spi_regbus_slave;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;
   localparam int ADDR_W     = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sclk = 1'b0;
   logic              cs_n = 1'b1;
   logic              mosi = 1'b0;
   logic              miso, miso_oe;
   logic [ADDR_W-1:0] reg_addr;
   logic [7:0]        reg_wdata;
   logic              reg_wr, reg_rd, crc_err;
   logic [7:0]        reg_rdata = 8'h00;

   int checks = 0;
   int errors = 0;

   logic [7:0]        mem [256];
   logic [ADDR_W-1:0] wr_addr_log [64];
   logic [7:0]        wr_data_log [64];
   logic [ADDR_W-1:0] rd_addr_log [64];
   int wr_n = 0, rd_n = 0, crc_n = 0, clash_n = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spi_regbus_slave #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sclk   (sclk),
      .spi_cs_n   (cs_n),
      .spi_mosi   (mosi),
      .spi_miso   (miso),
      .spi_miso_oe(miso_oe),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_rdata  (reg_rdata),
      .crc_err    (crc_err)
   );

   always @(posedge clk) if (reg_rd) reg_rdata <= mem[reg_addr[7:0]];

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_wr && reg_rd) clash_n++;
         if (reg_wr && wr_n < 64) begin
            wr_addr_log[wr_n] = reg_addr;
            wr_data_log[wr_n] = reg_wdata;
         end
         if (reg_wr) wr_n++;
         if (reg_rd && rd_n < 64) rd_addr_log[rd_n] = reg_addr;
         if (reg_rd) rd_n++;
         if (crc_err) crc_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_logs();
      wr_n = 0; rd_n = 0; crc_n = 0;
   endtask

   task automatic frame_open();
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic frame_close();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      sclk = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      xfer_bits(tx, 8, rx);
   endtask

   task automatic send_header(input logic [7:0] cmd, input logic [15:0] a);
      logic [7:0] rx;
      xfer(cmd, rx);
      xfer(a[7:0], rx);
      xfer(a[15:8], rx);
   endtask

   task automatic t_reset();
      chk(reg_wr == 1'b0, "R1 reg_wr", int'(reg_wr), 0);
      chk(reg_rd == 1'b0, "R1 reg_rd", int'(reg_rd), 0);
      chk(crc_err == 1'b0, "R1 crc_err", int'(crc_err), 0);
      chk(miso_oe == 1'b0, "R1 miso_oe", int'(miso_oe), 0);
   endtask

   task automatic t_write(input logic [15:0] a, input int n, input logic [1:0] junk,
                          input int extra, input string req);
      logic [7:0] rx;
      clear_logs();
      frame_open();
      chk(miso_oe == 1'b1, "R9 oe during frame", int'(miso_oe), 1);
      send_header({1'b1, 1'b0, junk, 4'(n - 1)}, a);
      for (int k = 0; k < n + extra; k++) xfer(8'(8'h5A ^ (k * 13)), rx);
      frame_close();
      chk(miso_oe == 1'b0, "R9 oe after frame", int'(miso_oe), 0);
      chk(wr_n == n, {req, " write count"}, wr_n, n);
      for (int k = 0; k < n && k < wr_n; k++) begin
         chk(wr_addr_log[k] == ADDR_W'(a + k), {req, " write addr"},
             int'(wr_addr_log[k]), int'(ADDR_W'(a + k)));
         chk(wr_data_log[k] == 8'(8'h5A ^ (k * 13)), {req, " write data"},
             int'(wr_data_log[k]), int'(8'(8'h5A ^ (k * 13))));
      end
   endtask

   task automatic t_read(input logic [15:0] a, input int n, input logic [1:0] junk,
                         input int extra, input string req);
      logic [7:0] rx;
      clear_logs();
      frame_open();
      send_header({1'b0, 1'b0, junk, 4'(n - 1)}, a);
      for (int k = 0; k < n + extra; k++) begin
         xfer(8'h00, rx);
         if (k < n)
            chk(rx == mem[8'(a + k)], {req, " miso byte"}, int'(rx), int'(mem[8'(a + k)]));
         else
            chk(rx == 8'h00, "R10 miso past count", int'(rx), 0);
      end
      frame_close();
      chk(rd_n == n, {req, " read count"}, rd_n, n);
      for (int k = 0; k < n && k < rd_n; k++)
         chk(rd_addr_log[k] == ADDR_W'(a + k), {req, " read addr"},
             int'(rd_addr_log[k]), int'(ADDR_W'(a + k)));
   endtask

   task automatic t_crc(input logic dir);
      logic [7:0] rx;
      clear_logs();
      frame_open();
      send_header({dir, 1'b1, 2'b00, 4'd3}, 16'h0044);
      for (int k = 0; k < 4; k++) xfer(8'hC3, rx);
      frame_close();
      chk(wr_n == 0 && rd_n == 0, "R6 no access with CRC flag", wr_n + rd_n, 0);
      chk(crc_n == 1, "R6 crc pulse count", crc_n, 1);
   endtask

   task automatic t_abort();
      logic [7:0] rx;
      clear_logs();
      frame_open();
      send_header(8'h83, 16'h0020);
      xfer(8'h11, rx);
      xfer_bits(8'hFF, 3, rx);
      frame_close();
      chk(wr_n == 1, "R8 partial byte dropped", wr_n, 1);
      frame_open();
      xfer_bits(8'h80, 4, rx);
      frame_close();
      t_write(16'h0030, 1, 2'b00, 0, "R8 frame after abort");
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write(16'h0012, 1, 2'b00, 0, "R4 single write");
      t_write(16'h0134, 4, 2'b00, 0, "R3 little-endian address");
      t_write(16'h00F8, 16, 2'b11, 0, "R2 full burst with bits 5:4 set");
      t_read(16'h0010, 1, 2'b00, 0, "R5 single read");
      t_read(16'h0040, 5, 2'b10, 0, "R5 burst read");
      t_read(16'h00FE, 3, 2'b00, 0, "R3 read across 0x100");
      t_crc(1'b1);
      t_crc(1'b0);
      t_write(16'h0060, 2, 2'b00, 3, "R7 extra bytes");
      t_abort();
      t_read(16'h0080, 1, 2'b00, 2, "R10 read past count");
      chk(clash_n == 0, "R11 strobes never together", clash_n, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule